// File: doc/BRIEF.md
# Serial-Link PHY Error Interrupt Controller

This block collects receive decode faults from a serial gigabit PHY and turns them into a single interrupt line. When a code-group error or a running-disparity error is reported, a status bit is set and stays set until it is cleared. A mask register selects which status bits reach the interrupt output. All four registers are 8 bits wide and sit on a word-aligned register read/write port.

Clearing is a deferred two-step handshake. Software first writes the bits it wants cleared into a selection register. It then sets the global-clear bit in a command register. The selected status bits drop a fixed number of cycles later. Software polls status until the bits read zero, then writes zero to the command register and to the selection register.

A counter tracks consecutive error events. When it reaches the configured limit, a one-cycle reset request is sent to the external reset sequencer, which is outside this block.

Top module: `serdes_irq_ctrl`

## Requirements
- R1: Command (offset 0xAC), clear-select (0xB0) and mask (0xB4) are 8-bit read/write registers; a write takes effect at the clock edge where `bus_wr` is high, and a read returns the stored byte combinationally. Status (0xB8) is read-only, and writes to it have no effect.
- R2: A read from any offset other than the four mapped ones returns zero.
- R3: A cycle with `evt_valid` high sets status bit 7 if `evt_code_err` is high and status bit 6 if `evt_disp_err` is high. The set bits stay set until cleared. The other status bits always read zero.
- R4: Status is unchanged by a nonzero clear-select while command bit 0 (global clear) is low. It is also unchanged by a zero clear-select while global clear is high.
- R5: Consider the edge at which global clear becomes 1. Selected status bits still read set after that edge and after each of the next three edges. They read zero after the fourth edge (CLR_LAT = 4).
- R6: Only status bits that are 1 in clear-select are cleared. Other set bits keep their value.
- R7: If an error event and an active clear hit the same status bit in the same cycle, the bit is set after that edge.
- R8: `irq` is high exactly when (status AND mask) is nonzero, with no added latency. Mask 0x00 keeps `irq` low; mask 0xC0 enables both error sources.
- R9: Each event with at least one error flag advances a consecutive-error count. The event that brings the count to 2 drives `reset_req` high for exactly the following cycle and returns the count to zero.
- R10: An event with `evt_valid` high and both error flags low returns the consecutive-error count to zero. The error count is independent of the mask.
- R11: After a synchronous reset (`rst_n` low at a clock edge), all registers read zero and `irq` and `reset_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_valid | input | 1 | Decoder event strobe |
| evt_code_err | input | 1 | Event carries a code-group error |
| evt_disp_err | input | 1 | Event carries a running-disparity error |
| irq | output | 1 | Masked interrupt request |
| reset_req | output | 1 | One-cycle PHY reset request |

## Verification
The assertions take four things for granted:
- `rst_n` is held low for at least one edge before normal operation, so every `$past` term refers to a reset or a driven value.
- The error flags are only meaningful together with `evt_valid`.
- Each bus write is a single-cycle strobe.
- Inputs are free of unknowns at every edge.

The bench keeps within these assumptions. It drives every input only at the falling edge and holds each operation for exactly one rising edge. It starts each phase with a reset of several cycles, and it draws its random operations from a closed set: an event with random flags, a random mask write, or an idle cycle.

// File: rtl/serdes_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets and bit positions for the PHY
// interrupt controller. Offsets are byte addresses on a word-aligned map.
package serdes_irq_pkg;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 8;
    localparam logic [7:0] OFF_CMD    = 8'hAC;
    localparam logic [7:0] OFF_CLRSEL = 8'hB0;
    localparam logic [7:0] OFF_MASK   = 8'hB4;
    localparam logic [7:0] OFF_STATUS = 8'hB8;
    localparam int GCLR_BIT   = 0;   // global-clear bit in command register
    localparam int CODE_BIT   = 7;   // code-group decode error
    localparam int DISP_BIT   = 6;   // running-disparity error
endpackage

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
// irq_regs: holds command, clear-select and mask registers and muxes
// readback. Assumes single-cycle write strobes; status is read-only and
// supplied by the status unit. Unmapped offsets read as zero.
module irq_regs
    import serdes_irq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int W  = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  status_in,
    output logic [W-1:0]  cmd_q,
    output logic [W-1:0]  clrsel_q,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  rdata
);
    localparam logic [AW-1:0] A_CMD = AW'(OFF_CMD);
    localparam logic [AW-1:0] A_CLR = AW'(OFF_CLRSEL);
    localparam logic [AW-1:0] A_MSK = AW'(OFF_MASK);
    localparam logic [AW-1:0] A_STS = AW'(OFF_STATUS);

    // Register write decode; status offset is deliberately not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            clrsel_q <= '0;
            mask_q   <= '0;
        end else if (wr_en) begin
            if (addr == A_CMD) cmd_q    <= wdata;
            if (addr == A_CLR) clrsel_q <= wdata;
            if (addr == A_MSK) mask_q   <= wdata;
        end
    end

    // Combinational readback mux, zero for unmapped offsets.
    always_comb begin
        rdata = '0;
        if (addr == A_CMD) rdata = cmd_q;
        if (addr == A_CLR) rdata = clrsel_q;
        if (addr == A_MSK) rdata = mask_q;
        if (addr == A_STS) rdata = status_in;
    end
endmodule

// File: rtl/irq_status.sv
`timescale 1ns/1ps
// irq_status: sticky status bits with a deferred, qualified clear.
// A clear window opens LAT edges after global clear rises and stays open
// while it is held; a same-cycle set always beats a clear. Assumes LAT >= 1.
module irq_status #(
    parameter int W   = 8,
    parameter int LAT = 4,
    localparam int CW = $clog2(LAT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_sel,
    input  logic         gclr,
    output logic [W-1:0] status
);
    logic [CW-1:0] dly_q;
    logic          clr_open;

    // Delay counter: counts edges with global clear high, saturates at LAT.
    always_ff @(posedge clk) begin
        if (!rst_n)              dly_q <= '0;
        else if (!gclr)          dly_q <= '0;
        else if (dly_q != CW'(LAT)) dly_q <= dly_q + 1'b1;
    end

    assign clr_open = gclr && (dly_q >= CW'(LAT - 1));

    // One sticky flop per status bit; set has priority over clear.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                         status[b] <= 1'b0;
            else if (set_bits[b])               status[b] <= 1'b1;
            else if (clr_open && clr_sel[b])    status[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_err_count.sv
`timescale 1ns/1ps
// irq_err_count: counts consecutive error events; the event that reaches
// LIMIT raises a registered one-cycle reset request and restarts the count.
// A non-error event restarts the count. Assumes LIMIT >= 1.
module irq_err_count #(
    parameter int LIMIT = 2,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_valid,
    input  logic evt_err,
    output logic reset_req
);
    logic [CW-1:0] cnt_q;

    // Consecutive-error tracking and request pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (evt_valid) begin
                if (!evt_err) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(LIMIT - 1)) begin
                    cnt_q     <= '0;
                    reset_req <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serdes_irq_ctrl.sv
`timescale 1ns/1ps
// serdes_irq_ctrl: top of the PHY error interrupt controller. Maps decoder
// events to status bits, gates them with the mask into irq, and forwards
// error events to the consecutive-error counter. Synchronous active-low reset.
module serdes_irq_ctrl
    import serdes_irq_pkg::*;
#(
    parameter int CLR_LAT   = 4,
    parameter int ERR_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              evt_valid,
    input  logic              evt_code_err,
    input  logic              evt_disp_err,
    output logic              irq,
    output logic              reset_req
);
    logic [REG_W-1:0] cmd_q, clrsel_q, mask_q, status_q, set_vec;
    logic             gclr;

    assign gclr = cmd_q[GCLR_BIT];

    // Map qualified decoder flags onto their status bit positions.
    always_comb begin
        set_vec           = '0;
        set_vec[CODE_BIT] = evt_valid && evt_code_err;
        set_vec[DISP_BIT] = evt_valid && evt_disp_err;
    end

    irq_regs #(.AW(ADDR_W), .W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .status_in(status_q),
        .cmd_q    (cmd_q),
        .clrsel_q (clrsel_q),
        .mask_q   (mask_q),
        .rdata    (bus_rdata)
    );

    irq_status #(.W(REG_W), .LAT(CLR_LAT)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bits(set_vec),
        .clr_sel (clrsel_q),
        .gclr    (gclr),
        .status  (status_q)
    );

    irq_err_count #(.LIMIT(ERR_LIMIT)) u_errcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(evt_valid),
        .evt_err  (evt_code_err || evt_disp_err),
        .reset_req(reset_req)
    );

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
// irq_ctrl_chk: property checker bound into serdes_irq_ctrl. Keeps its own
// count of cycles with global clear held, to time the clear window.
module irq_ctrl_chk
    import serdes_irq_pkg::*;
#(
    parameter int LAT = 4,
    localparam int CW = $clog2(LAT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] st,
    input logic [REG_W-1:0] mask,
    input logic [REG_W-1:0] clr_sel,
    input logic             gclr,
    input logic             irq,
    input logic             reset_req,
    input logic             evt_valid,
    input logic             evt_code_err,
    input logic             evt_disp_err
);
    logic [CW-1:0] held_q;

    // Independent count of edges with global clear high.
    always_ff @(posedge clk) begin
        if (!rst_n || !gclr)          held_q <= '0;
        else if (held_q != CW'(LAT))  held_q <= held_q + 1'b1;
    end

    // R5
    clr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(st) & ~st)) |-> ($past(gclr) && ($past(held_q) >= CW'(LAT - 1))));

    // R6
    clr_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st) & ~st) & ~$past(clr_sel)) == '0);

    // R7
    evt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code_err) |=> st[CODE_BIT]);

    // R8
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st & mask)) |-> irq);

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R9
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(evt_valid && (evt_code_err || evt_disp_err)));
endmodule

bind serdes_irq_ctrl irq_ctrl_chk #(.LAT(CLR_LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (status_q),
    .mask        (mask_q),
    .clr_sel     (clrsel_q),
    .gclr        (gclr),
    .irq         (irq),
    .reset_req   (reset_req),
    .evt_valid   (evt_valid),
    .evt_code_err(evt_code_err),
    .evt_disp_err(evt_disp_err)
);

// File: tb/sim_serdes_irq_ctrl.sv
`timescale 1ns/1ps
// Bench for serdes_irq_ctrl: directed corner cases, then seeded random
// events and mask writes checked against bench model functions.
module sim_serdes_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_valid = 1'b0, evt_code_err = 1'b0, evt_disp_err = 1'b0;
    logic       irq, reset_req;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    serdes_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
        .evt_code_err(evt_code_err), .evt_disp_err(evt_disp_err),
        .irq(irq), .reset_req(reset_req)
    );

    function automatic logic exp_irq(input logic [7:0] s, input logic [7:0] m);
        return |(s & m);
    endfunction

    function automatic logic [7:0] exp_status(input logic [7:0] s, input logic c, input logic d);
        return s | {c, d, 6'b0};
    endfunction

    // Returns the next count; req gets the expected request level.
    function automatic int exp_count(input int c, input logic err, output logic req);
        req = 1'b0;
        if (!err) return 0;
        if (c == 1) begin req = 1'b1; return 0; end
        return c + 1;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic evt(input logic c, input logic d);
        evt_valid = 1'b1; evt_code_err = c; evt_disp_err = d;
        tick();
        evt_valid = 1'b0; evt_code_err = 1'b0; evt_disp_err = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, st_m, mk_m;
        logic       rq;
        int         cnt_m;
        void'($urandom(32'd2718));
        @(negedge clk);
        do_reset();

        // R11 reset state
        rd(8'hAC, v); chk("R11 cmd", v, 0);
        rd(8'hB0, v); chk("R11 clrsel", v, 0);
        rd(8'hB4, v); chk("R11 mask", v, 0);
        rd(8'hB8, v); chk("R11 status", v, 0);
        chk("R11 irq", irq, 0); chk("R11 reset_req", reset_req, 0);

        // R1 readback, status write ignored; R2 unmapped
        wr(8'hB4, 8'h5A); rd(8'hB4, v); chk("R1 mask rb", v, 8'h5A);
        wr(8'hB0, 8'h3C); rd(8'hB0, v); chk("R1 clrsel rb", v, 8'h3C);
        wr(8'hAC, 8'h82); rd(8'hAC, v); chk("R1 cmd rb", v, 8'h82);
        wr(8'hB8, 8'hFF); rd(8'hB8, v); chk("R1 status ro", v, 0);
        rd(8'h00, v); chk("R2 off 00", v, 0);
        rd(8'hBC, v); chk("R2 off BC", v, 0);
        do_reset();

        // R3 latching, R8 gating
        evt(1'b1, 1'b0); rd(8'hB8, v); chk("R3 code bit", v, 8'h80);
        chk("R8 mask zero", irq, 0);
        wr(8'hB4, 8'h40); chk("R8 mask other bit", irq, 0);
        evt(1'b0, 1'b1); rd(8'hB8, v); chk("R3 disp bit", v, 8'hC0);
        chk("R8 mask 40", irq, 1);
        wr(8'hB4, 8'hC0); chk("R8 mask C0", irq, 1);
        repeat (3) tick(); rd(8'hB8, v); chk("R3 sticky", v, 8'hC0);

        // R4 clear-select without global clear
        wr(8'hB0, 8'hC0); repeat (6) tick();
        rd(8'hB8, v); chk("R4 no gclr", v, 8'hC0);
        // R4 global clear with zero selection
        wr(8'hB0, 8'h00); wr(8'hAC, 8'h01); repeat (6) tick();
        rd(8'hB8, v); chk("R4 zero sel", v, 8'hC0);
        wr(8'hAC, 8'h00);

        // R5 latency and R6 selectivity
        wr(8'hB0, 8'h80); wr(8'hAC, 8'h01);
        for (int k = 0; k < 4; k++) begin
            rd(8'hB8, v); chk("R5 still set", v, 8'hC0);
            tick();
        end
        rd(8'hB8, v); chk("R5 R6 cleared after 4", v, 8'h40);
        chk("R8 remaining bit", irq, 1);
        wr(8'hAC, 8'h00); wr(8'hB0, 8'h00);
        rd(8'hB8, v); chk("R4 finalize", v, 8'h40);

        // R7 event beats an open clear window
        wr(8'hB0, 8'hC0); wr(8'hAC, 8'h01); repeat (5) tick();
        rd(8'hB8, v); chk("R7 pre", v, 0);
        chk("R8 cleared irq", irq, 0);
        evt(1'b1, 1'b0); rd(8'hB8, v); chk("R7 event wins", v, 8'h80);
        tick(); rd(8'hB8, v); chk("R7 cleared next", v, 0);
        wr(8'hAC, 8'h00); wr(8'hB0, 8'h00);

        // R9 / R10 consecutive errors
        do_reset();
        evt(1'b1, 1'b0); chk("R9 first err", reset_req, 0);
        evt(1'b0, 1'b1); chk("R9 second err pulse", reset_req, 1);
        tick(); chk("R9 pulse one cycle", reset_req, 0);
        evt(1'b1, 1'b1); chk("R9 restart", reset_req, 0);
        evt(1'b0, 1'b0); chk("R10 no-err event", reset_req, 0);
        evt(1'b1, 1'b0); chk("R10 count restarted", reset_req, 0);
        evt(1'b1, 1'b0); chk("R9 after restart", reset_req, 1);

        // Random phase (R3 R8 R9 R10)
        do_reset();
        st_m = '0; mk_m = '0; cnt_m = 0;
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 3;
            if (op == 0) begin
                logic c, d;
                c = 1'($urandom); d = 1'($urandom);
                evt(c, d);
                st_m  = exp_status(st_m, c, d);
                cnt_m = exp_count(cnt_m, c | d, rq);
                chk("R9 R10 random req", reset_req, rq);
                rd(8'hB8, v); chk("R3 random status", v, st_m);
            end else if (op == 1) begin
                mk_m = 8'($urandom);
                wr(8'hB4, mk_m);
                chk("R9 random idle req", reset_req, 0);
            end else begin
                tick();
                chk("R9 random idle req", reset_req, 0);
            end
            chk("R8 random irq", irq, exp_irq(st_m, mk_m));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule